// File: doc/BRIEF.md
# Fast Standby Transmit Controller

This block controls one transmit direction of a serial link as it moves between normal traffic and a fast standby power state. While the direction is in normal operation, an enter request moves it into standby. The controller then sends one electrical-idle ordered set and stops driving the lanes. It stays quiet for as long as no traffic is waiting. When traffic becomes pending, it wakes the link with a burst of fast training sets and then returns to normal operation.

The length of the wake burst is not fixed. It is the count that the link partner advertised during training. That count is captured from a strobe and held until the next capture. Entry and exit are decided only by these hardware inputs. Each direction has its own instance, so one direction can sit in standby while the other keeps carrying traffic. The `tx_sel` output tells the lane datapath what to transmit in each cycle. The `substate` output shows where the controller is.

Top module: `stby_tx_ctrl`

## Requirements
- R1: After reset, `substate` is 0 (normal) and `tx_sel` is 0 (data).
- R2: In normal state, an `enter_req` sampled with `tx_pending` low moves the controller to `substate` 1 (entry) on the next cycle. It stays there for exactly one cycle, and in that cycle `tx_sel` is 1 (electrical-idle ordered set).
- R3: The entry state is always followed by `substate` 2 (idle) with `tx_sel` 3 (electrical idle, lanes not driven). The controller stays idle for every cycle in which `tx_pending` is sampled low.
- R4: `tx_pending` sampled high in the idle state moves the controller to `substate` 3 (wake burst) on the next cycle, with `tx_sel` 2 (fast training set).
- R5: The wake burst lasts exactly N consecutive cycles with `tx_sel` 2. On the following cycle the controller is back at `substate` 0 with `tx_sel` 0.
- R6: A cycle with `fts_cap_stb` high loads `fts_cap_val` into the held count N. A captured value of 0 is held as 1. The value held after reset is 1.
- R7: An `enter_req` sampled while `tx_pending` is high leaves the controller in normal state.
- R8: An `enter_req` in the idle state or during the burst has no effect. A capture strobe during a burst does not change that burst's length and applies from the next burst on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to enter standby |
| tx_pending | input | 1 | Traffic is waiting to be sent |
| fts_cap_stb | input | 1 | Capture strobe for the wake count |
| fts_cap_val | input | 8 | Wake count advertised by the partner |
| tx_sel | output | 2 | 0 data, 1 electrical-idle ordered set, 2 fast training set, 3 electrical idle |
| substate | output | 2 | 0 normal, 1 entry, 2 idle, 3 wake burst |

## Verification
Every result is one register stage behind the input that causes it. An enter request, a wake, or a capture sampled at one rising edge is visible on the outputs after that edge. The bench drives inputs on falling edges and reads outputs on the next falling edge. This way each check sees exactly one transition. The burst length is found by counting falling edges that show `tx_sel` 2, starting one cycle after `tx_pending` is raised. That count is compared with the bench's own model of the held count, where 0 becomes 1 and the last capture wins.

// File: rtl/stby_tx_pkg.sv
package stby_tx_pkg;

  typedef enum logic [1:0] {
    SS_NORMAL = 2'd0,
    SS_ENTRY  = 2'd1,
    SS_IDLE   = 2'd2,
    SS_BURST  = 2'd3
  } substate_t;

  typedef enum logic [1:0] {
    TXS_DATA  = 2'd0,
    TXS_EIOS  = 2'd1,
    TXS_FTS   = 2'd2,
    TXS_EIDLE = 2'd3
  } txsel_t;

  function automatic txsel_t sel_for(input substate_t s);
    case (s)
      SS_ENTRY: return TXS_EIOS;
      SS_IDLE:  return TXS_EIDLE;
      SS_BURST: return TXS_FTS;
      default:  return TXS_DATA;
    endcase
  endfunction

endpackage

// File: rtl/stby_fts_hold.sv
module stby_fts_hold #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb,
  input  logic [CNT_W-1:0] cap_val,
  output logic [CNT_W-1:0] n_held
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // A zero count from the partner still yields one training set.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       n_held <= ONE;
    else if (cap_stb) n_held <= eff_count(cap_val);
  end

  AST_HELD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    n_held != '0);  // R6
  AST_ZERO_AS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && cap_val == '0) |=> n_held == ONE);  // R6
endmodule

// File: rtl/stby_burst_cnt.sv
module stby_burst_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             last
);
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         remaining <= '0;
    else if (load)                      remaining <= load_val;
    else if (step && remaining != '0)   remaining <= remaining - 1'b1;
  end

  assign last = (remaining == {{(CNT_W-1){1'b0}}, 1'b1});

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> remaining != '0);  // R5
endmodule

// File: rtl/stby_tx_fsm.sv
module stby_tx_fsm
  import stby_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter_req,
  input  logic      tx_pending,
  input  logic      burst_last,
  output logic      burst_load,
  output logic      burst_step,
  output substate_t state
);
  substate_t nxt;
  logic enter_evt, wake_evt, burst_done;

  assign enter_evt  = (state == SS_NORMAL) && enter_req && !tx_pending;
  assign wake_evt   = (state == SS_IDLE) && tx_pending;
  assign burst_done = (state == SS_BURST) && burst_last;
  assign burst_load = wake_evt;
  assign burst_step = (state == SS_BURST);

  always_comb begin
    nxt = state;
    case (state)
      SS_NORMAL: if (enter_evt)  nxt = SS_ENTRY;
      SS_ENTRY:                  nxt = SS_IDLE;
      SS_IDLE:   if (wake_evt)   nxt = SS_BURST;
      SS_BURST:  if (burst_done) nxt = SS_NORMAL;
      default:                   nxt = SS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SS_NORMAL;
    else        state <= nxt;
  end

  AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    state == SS_ENTRY |=> state == SS_IDLE);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SS_IDLE && !tx_pending) |=> state == SS_IDLE);  // R3
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SS_IDLE && tx_pending) |=> state == SS_BURST);  // R4
  AST_ENTER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SS_NORMAL && tx_pending) |=> state == SS_NORMAL);  // R7
  AST_BURST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SS_BURST && !burst_last) |=> state == SS_BURST);  // R5
endmodule

// File: rtl/stby_tx_ctrl.sv
module stby_tx_ctrl
  import stby_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_req,
  input  logic             tx_pending,
  input  logic             fts_cap_stb,
  input  logic [CNT_W-1:0] fts_cap_val,
  output logic [1:0]       tx_sel,
  output logic [1:0]       substate
);
  logic [CNT_W-1:0] n_held;
  logic burst_load, burst_step, burst_last;
  substate_t state;

  stby_fts_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_stb(fts_cap_stb),
    .cap_val(fts_cap_val), .n_held(n_held)
  );

  stby_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(burst_load), .load_val(n_held),
    .step(burst_step), .last(burst_last)
  );

  stby_tx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .tx_pending(tx_pending),
    .burst_last(burst_last), .burst_load(burst_load),
    .burst_step(burst_step), .state(state)
  );

  assign substate = state;
  assign tx_sel   = sel_for(state);

  AST_EIOS_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sel == 2'd1) |-> $past(substate) == 2'd0);  // R2
endmodule

// File: tb/stby_tx_ctrl_test.sv
`timescale 1ns/1ps
module stby_tx_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic enter_req = 0, tx_pending = 0, fts_cap_stb = 0;
  logic [7:0] fts_cap_val = 0;
  logic [1:0] tx_sel, substate;
  int checks = 0, errors = 0;
  bit done = 0;
  int model_n = 1;

  always #5 clk = ~clk;

  stby_tx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .tx_pending(tx_pending),
    .fts_cap_stb(fts_cap_stb), .fts_cap_val(fts_cap_val),
    .tx_sel(tx_sel), .substate(substate)
  );

  function automatic int eff_n(input int v);
    return (v % 256 == 0) ? 1 : v % 256;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int ss, input int ts);
    chk(substate == ss[1:0], req, substate, ss);
    chk(tx_sel == ts[1:0], req, tx_sel, ts);
  endtask

  task automatic capture(input int v);
    @(negedge clk); fts_cap_stb = 1; fts_cap_val = v[7:0];
    @(negedge clk); fts_cap_stb = 0;
    model_n = eff_n(v);
  endtask

  // enter, idle for k cycles (optionally poking enter_req), then wake and count
  task automatic cycle_once(input int k, input bit poke, input int mid_cap);
    int cnt = 0;
    int exp_n;
    @(negedge clk); enter_req = 1;
    @(negedge clk); enter_req = 0;
    chk_state("R2", 1, 1);
    @(negedge clk);
    chk_state("R3", 2, 3);
    for (int i = 0; i < k; i++) begin
      enter_req = poke;
      @(negedge clk);
      chk_state(poke ? "R8" : "R3", 2, 3);
    end
    enter_req = 0;
    tx_pending = 1;
    @(negedge clk);
    chk_state("R4", 3, 2);
    exp_n = model_n;
    while (tx_sel == 2'd2 && cnt < 300) begin
      cnt++;
      if (mid_cap >= 0 && cnt == 1) begin
        fts_cap_stb = 1; fts_cap_val = mid_cap[7:0];
        model_n = eff_n(mid_cap);
      end else fts_cap_stb = 0;
      enter_req = poke;
      @(negedge clk);
    end
    fts_cap_stb = 0;
    enter_req = 0;
    chk(cnt == exp_n, (mid_cap >= 0 || poke) ? "R8" : "R5", cnt, exp_n);
    chk_state("R5", 0, 0);
    enter_req = 1;
    @(negedge clk); enter_req = 0;
    @(negedge clk);
    chk_state("R7", 0, 0);
    tx_pending = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk_state("R1", 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1", 0, 0);
    // R6: reset value of the count is one
    cycle_once(2, 0, -1);
    // R6: zero is held as one
    capture(0);
    cycle_once(1, 0, -1);
    capture(5);
    cycle_once(0, 0, -1);
    capture(255);
    cycle_once(3, 0, -1);
    // R8: pokes during idle and burst, capture during burst
    capture(4);
    cycle_once(4, 1, 9);
    cycle_once(1, 0, -1);   // uses 9, checks R6 capture took effect
    for (int it = 0; it < 30; it++) begin
      int v = (($urandom % 6) == 0) ? 0 : int'($urandom % 40);
      capture(v);
      cycle_once(int'($urandom % 6), bit'($urandom % 2), -1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule